// File: doc/BRIEF.md
# Gradient-Weighted Streaming Cost Aggregator

This block turns a stream of per-pixel matching costs into one disparity per pixel. It uses an aggregation support whose shape adapts to the reference image. The support has no fixed window. Each pixel's cost for every candidate disparity is added to a recursively decayed copy of its neighbour's aggregate. The decay factor is a weight that falls off exponentially with the intensity step between the two reference pixels. Strong edges therefore cut the support, and flat regions let it spread across the whole row or column.

Two one-directional recursions are chained. A horizontal pass runs left to right. Its results then feed a vertical pass that runs top to bottom. The vertical pass keeps one line of aggregated costs, one entry per column and per disparity, so nothing larger than a single line is stored. Each disparity is aggregated on its own, with no penalty that couples neighbouring disparities. A winner-takes-all stage then reports the disparity with the smallest fully aggregated cost, together with that cost.

Pixels arrive in raster order, one per accepted cycle. The first pixel of a frame is flagged with both the frame-start and row-start inputs, and the first pixel of every later row with the row-start input alone. Cycles with the valid input low may appear anywhere in the stream.

Top module: `gradient_weighted_aggregator`

## Requirements
- R1: `outValid` rises exactly one clock after each cycle in which `inValid` is high, and is low one clock after any cycle in which `inValid` is low. During such idle cycles, `outDisp` and `outCost` keep their previous values.
- R2: The weight for an absolute intensity difference k is an unsigned fixed-point value with 8 fractional bits. It follows w(0)=256 and w(k)=floor(w(k-1)*DECAY/256), where DECAY defaults to 230, which is about 256*exp(-1/9.5).
- R3: The horizontal aggregate of disparity d is H = cost(d) + floor(wH*Hleft(d)/256). Here wH is the weight of |pix - pixel to the left| and Hleft is the horizontal aggregate of the previous pixel in the same row.
- R4: On a pixel with `inSol` high, the horizontal aggregate equals the pointwise cost for every disparity.
- R5: Every sum saturates at 2^ACC_W-1, which is 4095 by default, instead of wrapping.
- R6: The vertical aggregate of disparity d is V = H(d) + floor(wV*Vabove(d)/256). Here wV is the weight of |pix - pixel above|, and Vabove is the vertical aggregate stored for the same column in the previous row.
- R7: On the first row of a frame (the row that starts with `inSof`), the vertical aggregate equals the horizontal aggregate.
- R8: `outDisp` is the index of the smallest vertical aggregate, with the lowest index winning a tie, and `outCost` is that smallest aggregate.
- R9: Cycles with `inValid` low change no internal state, so a stream with gaps gives the same outputs as the same stream without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A pixel and its costs are presented this cycle |
| inSof | input | 1 | First pixel of a frame (driven together with inSol) |
| inSol | input | 1 | First pixel of a row |
| inPix | input | PIX_W | Reference image intensity |
| inCost | input | NDISP*COST_W | Pointwise costs, disparity d in bits [d*COST_W +: COST_W] |
| outValid | output | 1 | Result for the previously accepted pixel |
| outDisp | output | $clog2(NDISP) | Winning disparity |
| outCost | output | ACC_W | Fully aggregated cost of the winner |

## Verification
Each disparity and cost result is registered once, so it is due on the first rising edge after the pixel is accepted. The bench drives on the falling edge and compares `outDisp` and `outCost` on the next falling edge against a software model of both recursions. For an idle cycle, the bench checks on the following falling edge that `outValid` is low and that the outputs still hold the previous result. A frame streamed with gaps must match the gapless model pixel for pixel.

// File: rtl/gwa_pkg.sv
package gwa_pkg;
  typedef struct packed {
    logic load;      // pixel accepted this cycle
    logic rowStart;  // horizontal recursion restarts
    logic topRow;    // vertical recursion bypassed
  } aggStrobe_t;
endpackage

// File: rtl/gwa_ctrl.sv
module gwa_ctrl
  import gwa_pkg::*;
#(
  parameter int IMG_W = 8,
  localparam int COL_W = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inSol,
  output aggStrobe_t       strobe,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] colReg;
  logic             topReg;
  logic             lineStart;

  always_comb begin
    lineStart       = inSol | inSof;
    strobe.load     = inValid;
    strobe.rowStart = lineStart;
    strobe.topRow   = inSof | (topReg & ~inSol);
    col             = lineStart ? '0 : colReg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      colReg <= '0;
      topReg <= 1'b1;
    end else if (inValid) begin
      colReg <= (col == COL_W'(IMG_W - 1)) ? '0 : col + 1'b1;
      topReg <= strobe.topRow;
    end
  end
endmodule

// File: rtl/gwa_weight.sv
module gwa_weight #(
  parameter int PIX_W = 8,
  parameter int FRAC  = 8,
  parameter int DECAY = 230,
  localparam int WW   = FRAC + 1,
  localparam int NUM  = 1 << PIX_W
) (
  input  logic [PIX_W-1:0] pixA,
  input  logic [PIX_W-1:0] pixB,
  output logic [WW-1:0]    weight
);
  function automatic int weightAt(input int k);
    int w;
    w = 1 << FRAC;
    for (int i = 0; i < k; i++) w = (w * DECAY) >> FRAC;
    return w;
  endfunction

  logic [WW-1:0]    tab [NUM];
  logic [PIX_W-1:0] diff;

  for (genvar k = 0; k < NUM; k++) begin : g_tab
    localparam logic [WW-1:0] WK = WW'(weightAt(k));
    assign tab[k] = WK;
  end

  assign diff   = (pixA > pixB) ? pixA - pixB : pixB - pixA;
  assign weight = tab[diff];
endmodule

// File: rtl/gwa_datapath.sv
module gwa_datapath
  import gwa_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COST_W = 8,
  parameter int ACC_W  = 12,
  parameter int NDISP  = 4,
  parameter int IMG_W  = 8,
  parameter int FRAC   = 8,
  parameter int DECAY  = 230,
  localparam int COL_W = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int WW    = FRAC + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  aggStrobe_t              strobe,
  input  logic [COL_W-1:0]        col,
  input  logic [PIX_W-1:0]        pix,
  input  logic [NDISP*COST_W-1:0] costVec,
  output logic [NDISP*ACC_W-1:0]  hAccVec,
  output logic [NDISP*ACC_W-1:0]  vAccVec
);
  localparam logic [ACC_W-1:0] MAXV = '1;

  function automatic logic [ACC_W-1:0] satAdd(input logic [ACC_W-1:0] a,
                                              input logic [ACC_W-1:0] b);
    logic [ACC_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[ACC_W] ? MAXV : s[ACC_W-1:0];
  endfunction

  logic [PIX_W-1:0] leftPix;
  logic [PIX_W-1:0] abovePix;
  logic [PIX_W-1:0] linePix [IMG_W];
  logic [WW-1:0]    wH, wV;

  assign abovePix = linePix[col];

  gwa_weight #(.PIX_W(PIX_W), .FRAC(FRAC), .DECAY(DECAY)) u_wHoriz (
    .pixA(pix), .pixB(leftPix), .weight(wH));
  gwa_weight #(.PIX_W(PIX_W), .FRAC(FRAC), .DECAY(DECAY)) u_wVert (
    .pixA(pix), .pixB(abovePix), .weight(wV));

  always_ff @(posedge clk) begin
    if (!rst_n) leftPix <= '0;
    else if (strobe.load) leftPix <= pix;
  end

  always_ff @(posedge clk) begin
    if (strobe.load) linePix[col] <= pix;
  end

  for (genvar d = 0; d < NDISP; d++) begin : g_disp
    logic [COST_W-1:0]   costD;
    logic [ACC_W-1:0]    hReg;
    logic [ACC_W-1:0]    colMem [IMG_W];
    logic [ACC_W-1:0]    above;
    logic [ACC_W+WW-1:0] hProd, vProd;
    logic [ACC_W-1:0]    hNew, vNew;

    assign costD = costVec[d*COST_W +: COST_W];
    assign above = colMem[col];
    assign hProd = wH * hReg;
    assign vProd = wV * above;

    always_comb begin
      if (strobe.rowStart) hNew = ACC_W'(costD);
      else                 hNew = satAdd(ACC_W'(costD), ACC_W'(hProd >> FRAC));
      if (strobe.topRow)   vNew = hNew;
      else                 vNew = satAdd(hNew, ACC_W'(vProd >> FRAC));
    end

    always_ff @(posedge clk) begin
      if (!rst_n) hReg <= '0;
      else if (strobe.load) hReg <= hNew;
    end

    always_ff @(posedge clk) begin
      if (strobe.load) colMem[col] <= vNew;
    end

    assign hAccVec[d*ACC_W +: ACC_W] = hNew;
    assign vAccVec[d*ACC_W +: ACC_W] = vNew;
  end
endmodule

// File: rtl/gwa_wta.sv
module gwa_wta #(
  parameter int ACC_W  = 12,
  parameter int NDISP  = 4,
  localparam int DISP_W = (NDISP > 1) ? $clog2(NDISP) : 1
) (
  input  logic [NDISP*ACC_W-1:0] accVec,
  output logic [DISP_W-1:0]      bestIdx,
  output logic [ACC_W-1:0]       bestCost
);
  always_comb begin
    bestIdx  = '0;
    bestCost = accVec[ACC_W-1:0];
    for (int d = 1; d < NDISP; d++) begin
      if (accVec[d*ACC_W +: ACC_W] < bestCost) begin
        bestCost = accVec[d*ACC_W +: ACC_W];
        bestIdx  = DISP_W'(d);
      end
    end
  end
endmodule

// File: rtl/gradient_weighted_aggregator.sv
module gradient_weighted_aggregator
  import gwa_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COST_W = 8,
  parameter int ACC_W  = 12,
  parameter int NDISP  = 4,
  parameter int IMG_W  = 8,
  parameter int FRAC   = 8,
  parameter int DECAY  = 230,
  localparam int COL_W  = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int DISP_W = (NDISP > 1) ? $clog2(NDISP) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inValid,
  input  logic                    inSof,
  input  logic                    inSol,
  input  logic [PIX_W-1:0]        inPix,
  input  logic [NDISP*COST_W-1:0] inCost,
  output logic                    outValid,
  output logic [DISP_W-1:0]       outDisp,
  output logic [ACC_W-1:0]        outCost
);
  aggStrobe_t               strobe;
  logic [COL_W-1:0]         col;
  logic [NDISP*ACC_W-1:0]   hAccVec;
  logic [NDISP*ACC_W-1:0]   vAccVec;
  logic [DISP_W-1:0]        winIdx;
  logic [ACC_W-1:0]         winCost;

  gwa_ctrl #(.IMG_W(IMG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSof(inSof),
    .inSol(inSol), .strobe(strobe), .col(col));

  gwa_datapath #(
    .PIX_W(PIX_W), .COST_W(COST_W), .ACC_W(ACC_W), .NDISP(NDISP),
    .IMG_W(IMG_W), .FRAC(FRAC), .DECAY(DECAY)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .col(col), .pix(inPix),
    .costVec(inCost), .hAccVec(hAccVec), .vAccVec(vAccVec));

  gwa_wta #(.ACC_W(ACC_W), .NDISP(NDISP)) u_wta (
    .accVec(vAccVec), .bestIdx(winIdx), .bestCost(winCost));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outDisp  <= '0;
      outCost  <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outDisp <= winIdx;
        outCost <= winCost;
      end
    end
  end
endmodule

// File: rtl/gwa_check.sv
module gwa_check #(
  parameter int COST_W = 8,
  parameter int ACC_W  = 12,
  parameter int NDISP  = 4,
  localparam int DISP_W = (NDISP > 1) ? $clog2(NDISP) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    inValid,
  input logic                    inSof,
  input logic                    inSol,
  input logic [NDISP*COST_W-1:0] inCost,
  input logic [NDISP*ACC_W-1:0]  hAccVec,
  input logic [NDISP*ACC_W-1:0]  vAccVec,
  input logic                    outValid,
  input logic [DISP_W-1:0]       outDisp,
  input logic [ACC_W-1:0]        outCost
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> (!outValid && $stable(outDisp) && $stable(outCost)));
  p_disp_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (32'(outDisp) < NDISP));

  for (genvar d = 0; d < NDISP; d++) begin : g_chk
    logic [COST_W-1:0] c;
    logic [ACC_W-1:0]  h, v;
    assign c = inCost[d*COST_W +: COST_W];
    assign h = hAccVec[d*ACC_W +: ACC_W];
    assign v = vAccVec[d*ACC_W +: ACC_W];

    p_row_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inValid && inSol) |-> (h == ACC_W'(c)));
    p_no_shrink_r3: assert property (@(posedge clk) disable iff (!rst_n)
      inValid |-> (h >= ACC_W'(c)));
    p_vert_ge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      inValid |-> (v >= h));
    p_top_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inValid && inSof) |-> (v == h));
    p_min_cost_r8: assert property (@(posedge clk) disable iff (!rst_n)
      inValid |=> (outCost <= $past(v)));
  end
endmodule

bind gradient_weighted_aggregator gwa_check #(
  .COST_W(COST_W), .ACC_W(ACC_W), .NDISP(NDISP)
) u_gwa_check (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSof(inSof), .inSol(inSol),
  .inCost(inCost), .hAccVec(hAccVec), .vAccVec(vAccVec),
  .outValid(outValid), .outDisp(outDisp), .outCost(outCost));

// File: tb/gradient_weighted_aggregator_test.sv
`timescale 1ns/1ps
module gradient_weighted_aggregator_test;
  localparam int PIX_W = 8, COST_W = 8, ACC_W = 12, NDISP = 4;
  localparam int IMG_W = 8, ROWS = 8, DECAY = 230;
  localparam int MAXV = (1 << ACC_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, inSol = 1'b0;
  logic [PIX_W-1:0] inPix = '0;
  logic [NDISP*COST_W-1:0] inCost = '0;
  logic outValid;
  logic [1:0] outDisp;
  logic [ACC_W-1:0] outCost;

  int checks = 0, errors = 0, cycles = 0;
  int unsigned seed = 32'h1234_5678;
  bit done = 0;

  int pixA [ROWS][IMG_W];
  int costA [ROWS][IMG_W][NDISP];
  int vPrev [IMG_W][NDISP];

  always #2.5 clk = ~clk;

  gradient_weighted_aggregator #(.DECAY(DECAY)) uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSof(inSof), .inSol(inSol),
    .inPix(inPix), .inCost(inCost), .outValid(outValid), .outDisp(outDisp),
    .outCost(outCost));

  function automatic int nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed >> 16);
  endfunction

  function automatic int wgt(input int k);
    int w = 256;
    for (int i = 0; i < k; i++) w = (w * DECAY) / 256;
    return w;
  endfunction

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic int sat(input int s);
    return (s > MAXV) ? MAXV : s;
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // mode 0: noisy pixels, 1: smooth pixels, 2: flat with maximal costs, 3: smooth with gaps
  task automatic runFrame(input int mode);
    int hPrev [NDISP];
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < IMG_W; c++) begin
        case (mode)
          0: pixA[r][c] = nextRand() & 255;
          2: pixA[r][c] = 100;
          default: pixA[r][c] = 120 + r * 2 + c + (nextRand() & 3);
        endcase
        for (int d = 0; d < NDISP; d++)
          costA[r][c][d] = (mode == 2) ? 255 : (nextRand() & 255);
      end
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < IMG_W; c++) begin
        int vNow [NDISP];
        int bestD, bestC, prevDisp, prevCost;
        string tag;
        for (int d = 0; d < NDISP; d++) begin
          int h;
          if (c == 0) h = costA[r][c][d];                                     // R4
          else h = sat(costA[r][c][d] + (wgt(absd(pixA[r][c], pixA[r][c-1])) * hPrev[d]) / 256); // R2 R3
          hPrev[d] = h;
          if (r == 0) vNow[d] = h;                                            // R7
          else vNow[d] = sat(h + (wgt(absd(pixA[r][c], pixA[r-1][c])) * vPrev[c][d]) / 256);   // R6
        end
        bestD = 0; bestC = vNow[0];
        for (int d = 1; d < NDISP; d++)
          if (vNow[d] < bestC) begin bestC = vNow[d]; bestD = d; end          // R8
        for (int d = 0; d < NDISP; d++) vPrev[c][d] = vNow[d];
        tag = "R2 R3 R6 R8";
        if (c == 0) tag = {tag, " R4"};
        if (r == 0) tag = {tag, " R7"};
        if (mode == 2) tag = {tag, " R5"};
        if (mode == 3) tag = {tag, " R9"};
        inValid = 1'b1;
        inSol = (c == 0);
        inSof = (c == 0 && r == 0);
        inPix = PIX_W'(pixA[r][c]);
        for (int d = 0; d < NDISP; d++) inCost[d*COST_W +: COST_W] = COST_W'(costA[r][c][d]);
        @(negedge clk);
        check("R1", int'(outValid), 1, "outValid after pixel");
        check(tag, int'(outDisp), bestD, $sformatf("disp m%0d r%0d c%0d", mode, r, c));
        check(tag, int'(outCost), bestC, $sformatf("cost m%0d r%0d c%0d", mode, r, c));
        if (mode == 3) begin
          prevDisp = bestD; prevCost = bestC;
          inValid = 1'b0;
          inSol = 1'b1; inSof = (c == 3);   // junk flags during idle must be ignored
          inPix = PIX_W'(nextRand());
          inCost = NDISP*COST_W'(nextRand());
          repeat (1 + (c % 2)) @(negedge clk);
          check("R1", int'(outValid), 0, "outValid after idle");
          check("R1", int'(outDisp), prevDisp, "disp held in idle");
          check("R1", int'(outCost), prevCost, "cost held in idle");
        end
      end
    inValid = 1'b0; inSol = 1'b0; inSof = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", int'(outValid), 0, "reset outValid");
    check("R1", int'(outDisp), 0, "reset outDisp");
    check("R1", int'(outCost), 0, "reset outCost");
    runFrame(0);
    runFrame(1);
    runFrame(2);
    runFrame(3);
    runFrame(0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule